// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Write Protection

This block translates 32-bit virtual addresses into physical addresses for 4 KB pages. It is built from a small, fully associative set of entries. Every entry holds a virtual page tag and a physical page number, plus three flags: valid, dirty and write-permitted. A lookup compares the virtual page number with all entries in the same cycle. The result is one of three outcomes: a translated physical address with a hit, a miss exception, or a write-protection exception. A successful write marks the entry dirty.

Software installs translations through a refill port. The entry to write is chosen in this order:

1. An entry that already holds the same virtual page number.
2. Otherwise, the lowest-numbered invalid entry.
3. Otherwise, a victim picked by a free-running pseudo-random sequence.

A flush input invalidates the whole buffer in one cycle. Page-table walking, multiple page sizes and address-space tags are handled elsewhere.

Top module: `tlb_xlate`

## Requirements
- R1: The physical address on a hit is the entry's physical page number in bits 31..12, with the 12-bit page offset (bits 11..0) copied unchanged from the virtual address. The virtual page number is bits 31..12.
- R2: A lookup whose virtual page number matches no valid entry asserts the miss output. While the miss output is high, the physical address output is zero.
- R3: A write lookup that matches an entry with the write-permit flag clear does three things: it asserts the protection output, it leaves hit low with a zero physical address, and it does not change that entry's dirty flag.
- R4: A read lookup that matches an entry with the write-permit flag clear is an ordinary hit.
- R5: A write hit sets the dirty flag of the matched entry. The dirty output reports that flag as it stood before the current access. It is 0 on the first write after a refill and 1 on later ones. Reads never set the flag.
- R6: Lookup outputs are combinational from the current contents. A refill or flush changes the contents at the next rising clock edge, so a lookup in the same cycle does not see the change.
- R7: A refill whose virtual page number is already present overwrites that entry. The result is never two valid entries with the same tag. Every refill clears the dirty flag of the entry it writes.
- R8: While any entry is invalid, a refill uses an invalid entry, so every translation already present still hits afterwards.
- R9: When all entries are valid, a refill of a new page replaces exactly one existing translation, chosen pseudo-randomly. The new page then hits.
- R10: A flush invalidates all entries at the next edge. A refill in the same cycle as a flush is discarded.
- R11: After reset every entry is invalid, so every lookup misses.
- R12: When a lookup is requested, exactly one of hit, miss and protection is high. With no lookup requested, all three are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| lk_en | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a write access |
| lk_addr | input | VA_W (32) | Virtual address to translate |
| lk_hit | output | 1 | Translation succeeded |
| lk_miss | output | 1 | Miss exception |
| lk_wprot | output | 1 | Write-protection exception |
| lk_dirty | output | 1 | Dirty flag of the matched entry before this access |
| lk_paddr | output | PA_W (32) | Physical address, zero unless hit |
| fill_en | input | 1 | Refill request |
| fill_vpn | input | VA_W-12 (20) | Virtual page number to install |
| fill_ppn | input | PA_W-12 (20) | Physical page number to install |
| fill_wperm | input | 1 | Write permission for the installed page |

## Verification
The assertions assume that lookups and refills come only from the ports and that reset is applied before any traffic. They also assume that at most one lookup is presented per cycle. The dirty-flag properties further assume that no refill or flush lands in the same cycle as the write they observe. For that reason they are qualified with the absence of both.

The bench keeps within these assumptions in several ways. It drives inputs on the falling edge and holds each lookup for exactly one rising edge. It keeps refills and lookups in separate cycles, except in the one deliberate same-cycle case. It uses distinct virtual page numbers, except where it overwrites on purpose.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  // Fibonacci step, taps 16,15,13,4
  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
  endfunction

  typedef enum logic [1:0] {
    RES_NONE  = 2'd0,
    RES_HIT   = 2'd1,
    RES_MISS  = 2'd2,
    RES_WPROT = 2'd3
  } tlb_res_e;
endpackage

// File: rtl/tlb_lfsr.sv
module tlb_lfsr
  import tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic [LFSR_W-1:0] state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= LFSR_SEED;
    else        state <= lfsr_next(state);
  end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
  parameter int N  = 64,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  // lowest set bit wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int N     = 64,
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int IW    = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             wr_perm,
  input  logic             dset_en,
  input  logic [IW-1:0]    dset_idx,
  output logic [N-1:0]     lk_match,
  output logic [N-1:0]     wr_match,
  output logic [N-1:0]     valid_vec,
  output logic [N-1:0]     dirty_vec,
  output logic [N-1:0]     perm_vec,
  output logic [PPN_W-1:0] ppn_tab [N]
);
  logic [VPN_W-1:0] tag_q [N];
  logic [PPN_W-1:0] ppn_q [N];
  logic [N-1:0]     valid_q, dirty_q, perm_q;

  for (genvar e = 0; e < N; e++) begin : g_ent
    assign lk_match[e] = valid_q[e] && (tag_q[e] == lk_vpn);
    assign wr_match[e] = valid_q[e] && (tag_q[e] == wr_vpn);
    assign ppn_tab[e]  = ppn_q[e];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[e] <= 1'b0;
        dirty_q[e] <= 1'b0;
        perm_q[e]  <= 1'b0;
      end else if (clr_all) begin
        valid_q[e] <= 1'b0;
        dirty_q[e] <= 1'b0;
      end else if (wr_en && wr_idx == IW'(e)) begin
        valid_q[e] <= 1'b1;
        dirty_q[e] <= 1'b0;
        perm_q[e]  <= wr_perm;
      end else if (dset_en && dset_idx == IW'(e)) begin
        dirty_q[e] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!clr_all && wr_en && wr_idx == IW'(e)) begin
        tag_q[e] <= wr_vpn;
        ppn_q[e] <= wr_ppn;
      end
    end
  end

  assign valid_vec = valid_q;
  assign dirty_vec = dirty_q;
  assign perm_vec  = perm_q;
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int PG_W    = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 lk_en,
  input  logic                 lk_write,
  input  logic [VA_W-1:0]      lk_addr,
  output logic                 lk_hit,
  output logic                 lk_miss,
  output logic                 lk_wprot,
  output logic                 lk_dirty,
  output logic [PA_W-1:0]      lk_paddr,
  input  logic                 fill_en,
  input  logic [VA_W-PG_W-1:0] fill_vpn,
  input  logic [PA_W-PG_W-1:0] fill_ppn,
  input  logic                 fill_wperm
);
  localparam int VPN_W = VA_W - PG_W;
  localparam int PPN_W = PA_W - PG_W;
  localparam int IW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  function automatic logic [VPN_W-1:0] vpn_of(input logic [VA_W-1:0] a);
    return a[VA_W-1:PG_W];
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [PPN_W-1:0] p,
                                              input logic [VA_W-1:0] a);
    return {p, a[PG_W-1:0]};
  endfunction

  function automatic logic [IW-1:0] victim_of(input logic [LFSR_W-1:0] s);
    return IW'(s % LFSR_W'(ENTRIES));
  endfunction

  // named internal events, used by the bound checker
  logic [ENTRIES-1:0] hit_vec, fmatch_vec, valid_vec, dirty_vec, perm_vec;
  logic [PPN_W-1:0]   ppn_tab [ENTRIES];
  logic               hit_any, fmatch_any, free_any;
  logic [IW-1:0]      hit_idx, fmatch_idx, free_idx, fill_idx;
  logic [LFSR_W-1:0]  rnd;
  logic               dirty_set;
  tlb_res_e           res;

  tlb_store #(.N(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .IW(IW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_all  (flush),
    .lk_vpn   (vpn_of(lk_addr)),
    .wr_vpn   (fill_vpn),
    .wr_en    (fill_en),
    .wr_idx   (fill_idx),
    .wr_ppn   (fill_ppn),
    .wr_perm  (fill_wperm),
    .dset_en  (dirty_set),
    .dset_idx (hit_idx),
    .lk_match (hit_vec),
    .wr_match (fmatch_vec),
    .valid_vec(valid_vec),
    .dirty_vec(dirty_vec),
    .perm_vec (perm_vec),
    .ppn_tab  (ppn_tab)
  );

  tlb_pick #(.N(ENTRIES), .IW(IW)) u_pick_hit (
    .vec(hit_vec), .found(hit_any), .idx(hit_idx));
  tlb_pick #(.N(ENTRIES), .IW(IW)) u_pick_dup (
    .vec(fmatch_vec), .found(fmatch_any), .idx(fmatch_idx));
  tlb_pick #(.N(ENTRIES), .IW(IW)) u_pick_free (
    .vec(~valid_vec), .found(free_any), .idx(free_idx));

  tlb_lfsr u_lfsr (.clk(clk), .rst_n(rst_n), .state(rnd));

  always_comb begin
    if (fmatch_any)    fill_idx = fmatch_idx;
    else if (free_any) fill_idx = free_idx;
    else               fill_idx = victim_of(rnd);
  end

  always_comb begin
    if (!lk_en)                                 res = RES_NONE;
    else if (!hit_any)                          res = RES_MISS;
    else if (lk_write && !perm_vec[hit_idx])    res = RES_WPROT;
    else                                        res = RES_HIT;
  end

  assign lk_hit    = (res == RES_HIT);
  assign lk_miss   = (res == RES_MISS);
  assign lk_wprot  = (res == RES_WPROT);
  assign lk_dirty  = lk_en && hit_any && dirty_vec[hit_idx];
  assign lk_paddr  = lk_hit ? join_pa(ppn_tab[hit_idx], lk_addr) : '0;
  assign dirty_set = lk_hit && lk_write;
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int N    = 64,
  parameter int PG_W = 12,
  parameter int IW   = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          fill_en,
  input logic          lk_en,
  input logic          lk_write,
  input logic [31:0]   lk_addr,
  input logic [31:0]   lk_paddr,
  input logic          lk_hit,
  input logic          lk_miss,
  input logic          lk_wprot,
  input logic [N-1:0]  hit_vec,
  input logic [IW-1:0] hit_idx,
  input logic [N-1:0]  dirty_vec
);
  assert_one_result_R12: assert property (@(posedge clk) disable iff (!rst_n)
    lk_en |-> $onehot({lk_hit, lk_miss, lk_wprot}));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_en |-> !(lk_hit || lk_miss || lk_wprot));

  assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_paddr[PG_W-1:0] == lk_addr[PG_W-1:0]);

  assert_no_dup_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  assert_dirty_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_write && !flush && !fill_en) |=> dirty_vec[$past(hit_idx)]);

  assert_wprot_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_wprot && !flush && !fill_en) |=> $stable(dirty_vec));

  assert_flush_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (lk_en |-> lk_miss));
endmodule

bind tlb_xlate tlb_xlate_chk #(.N(ENTRIES), .PG_W(PG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .flush    (flush),
  .fill_en  (fill_en),
  .lk_en    (lk_en),
  .lk_write (lk_write),
  .lk_addr  (lk_addr),
  .lk_paddr (lk_paddr),
  .lk_hit   (lk_hit),
  .lk_miss  (lk_miss),
  .lk_wprot (lk_wprot),
  .hit_vec  (hit_vec),
  .hit_idx  (hit_idx),
  .dirty_vec(dirty_vec)
);

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic lk_en = 1'b0, lk_write = 1'b0;
  logic [31:0] lk_addr = '0;
  logic lk_hit, lk_miss, lk_wprot, lk_dirty;
  logic [31:0] lk_paddr;
  logic fill_en = 1'b0, fill_wperm = 1'b0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;

  int checks = 0, fails = 0;
  logic [19:0] mv [N];
  logic [19:0] mp [N];
  logic        mw [N];
  logic        r_hit, r_miss, r_wp, r_dirty;
  logic [31:0] r_pa;

  always #4 clk = ~clk;

  tlb_xlate #(.ENTRIES(N)) uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lk_en(lk_en), .lk_write(lk_write),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_wprot(lk_wprot),
    .lk_dirty(lk_dirty), .lk_paddr(lk_paddr), .fill_en(fill_en), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_wperm(fill_wperm));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] a, input logic w);
    @(negedge clk);
    lk_en = 1'b1; lk_addr = a; lk_write = w;
    #1;
    r_hit = lk_hit; r_miss = lk_miss; r_wp = lk_wprot; r_dirty = lk_dirty; r_pa = lk_paddr;
    @(posedge clk); #1;
    lk_en = 1'b0; lk_write = 1'b0;
  endtask

  task automatic fill(input logic [19:0] v, input logic [19:0] p, input logic w);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = v; fill_ppn = p; fill_wperm = w;
    @(posedge clk); #1;
    fill_en = 1'b0;
  endtask

  function automatic logic [11:0] offs(input int i, input int k);
    return 12'((i * 613 + k * 1021) & 12'hFFF);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R6 watchdog actual=%h expected=%h", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int nmiss, lost;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R12 idle, R11 reset state
    @(negedge clk); #1;
    chk(!lk_hit && !lk_miss && !lk_wprot, "R12 idle", {lk_hit, lk_miss, lk_wprot}, 0);
    for (int i = 0; i < N; i++) begin
      look({20'h40000 + 20'(i * 37), 12'h0}, 1'b0);
      chk(r_miss && !r_hit && r_pa == 0, "R11 reset miss", {r_hit, r_miss}, 1);
    end
    // fill all entries; odd ones are writable
    for (int i = 0; i < N; i++) begin
      mv[i] = 20'h40000 + 20'(i * 37);
      mp[i] = 20'hA0000 ^ 20'(i * 291 + 5);
      mw[i] = i[0];
      fill(mv[i], mp[i], mw[i]);
    end
    // R1/R8 translation sweep; R4 reads to protected entries
    for (int i = 0; i < N; i++)
      for (int k = 0; k < 4; k++) begin
        look({mv[i], offs(i, k)}, 1'b0);
        chk(r_hit && r_pa == {mp[i], offs(i, k)}, "R1 R8 R4 hit paddr", r_pa,
            {mp[i], offs(i, k)});
      end
    // R5 / R3 writes
    for (int i = 0; i < N; i++) begin
      look({mv[i], 12'h010}, 1'b0);
      chk(r_dirty == 1'b0, "R5 read keeps clean", r_dirty, 0);
      look({mv[i], 12'h020}, 1'b1);
      if (mw[i]) begin
        chk(r_hit && r_dirty == 1'b0, "R5 first write", {r_hit, r_dirty}, 2);
        look({mv[i], 12'h030}, 1'b1);
        chk(r_hit && r_dirty == 1'b1, "R5 second write", {r_hit, r_dirty}, 3);
      end else begin
        chk(r_wp && !r_hit && r_pa == 0, "R3 protect", {r_wp, r_hit, r_pa[7:0]}, 32'h200);
        look({mv[i], 12'h030}, 1'b1);
        chk(r_wp && r_dirty == 1'b0, "R3 dirty unchanged", {r_wp, r_dirty}, 2);
        look({mv[i], 12'h040}, 1'b0);
        chk(r_hit && r_dirty == 1'b0, "R4 read of protected", {r_hit, r_dirty}, 2);
      end
    end
    // R2 miss sweep
    for (int i = 0; i < 16; i++) begin
      look({20'h90000 + 20'(i * 113), offs(i, 1)}, i[0]);
      chk(r_miss && !r_hit && !r_wp && r_pa == 0, "R2 miss", {r_hit, r_miss, r_wp}, 2);
    end
    // R7 overwrite existing VPN (entry 3 was writable and dirty)
    mp[3] = 20'h0BEEF; mw[3] = 1'b0;
    fill(mv[3], mp[3], mw[3]);
    look({mv[3], 12'h123}, 1'b0);
    chk(r_hit && r_pa == {mp[3], 12'h123} && !r_dirty, "R7 overwrite", r_pa,
        {mp[3], 12'h123});
    look({mv[3], 12'h123}, 1'b1);
    chk(r_wp, "R7 new permission", r_wp, 1);
    for (int i = 0; i < N; i++) begin
      look({mv[i], 12'h777}, 1'b0);
      chk(r_hit && r_pa == {mp[i], 12'h777}, "R7 no eviction", r_pa, {mp[i], 12'h777});
    end
    // R9 replacement when full
    for (int j = 0; j < 5; j++) begin
      fill(20'h70000 + 20'(j), 20'h30000 + 20'(j), 1'b1);
      nmiss = 0; lost = 0;
      for (int i = 0; i < N; i++) begin
        look({mv[i], 12'h0}, 1'b0);
        if (r_miss) begin nmiss++; lost = i; end
        else chk(r_pa == {mp[i], 12'h0}, "R9 survivor", r_pa, {mp[i], 12'h0});
      end
      chk(nmiss == 1, "R9 exactly one evicted", nmiss, 1);
      mv[lost] = 20'h70000 + 20'(j); mp[lost] = 20'h30000 + 20'(j); mw[lost] = 1'b1;
      look({mv[lost], 12'hABC}, 1'b0);
      chk(r_hit && r_pa == {mp[lost], 12'hABC}, "R9 new hit", r_pa, {mp[lost], 12'hABC});
    end
    // R10 flush beats simultaneous refill
    @(negedge clk);
    flush = 1'b1; fill_en = 1'b1; fill_vpn = 20'h55555; fill_ppn = 20'h11111; fill_wperm = 1'b1;
    @(posedge clk); #1;
    flush = 1'b0; fill_en = 1'b0;
    for (int i = 0; i < N; i++) begin
      look({mv[i], 12'h0}, 1'b0);
      chk(r_miss, "R10 flushed", r_miss, 1);
    end
    look({20'h55555, 12'h0}, 1'b0);
    chk(r_miss, "R10 refill dropped", r_miss, 1);
    // R6 refill visible only after the edge
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = 20'h12345; fill_ppn = 20'h6789A; fill_wperm = 1'b1;
    lk_en = 1'b1; lk_addr = 32'h12345_FED; lk_write = 1'b0;
    #1;
    chk(lk_miss && !lk_hit, "R6 same cycle miss", {lk_hit, lk_miss}, 1);
    @(posedge clk); #1;
    fill_en = 1'b0;
    #1;
    chk(lk_hit && lk_paddr == 32'h6789A_FED, "R6 next cycle hit", lk_paddr, 32'h6789AFED);
    lk_en = 1'b0;
    #1;
    chk(!lk_hit && !lk_miss && !lk_wprot, "R12 idle after", {lk_hit, lk_miss, lk_wprot}, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule